// File: doc/BRIEF.md
# Multi-Mode Down-Counter Timer Channel

This block is one channel of a programmable interval timer. It holds a count that steps down by one each time a qualified count pulse arrives from an external prescaler while the channel is enabled. When the active part of the count is found at zero on such a pulse, the channel raises a one-cycle event. What the count does next depends on the mode. In wrap mode it goes to all-ones. In periodic mode it takes the reload value. In one-shot mode it stops.

Software reaches the channel through three write strobes, all decoded by a neighbouring bus block. The first writes an 8-bit control word. The second is a direct load, which replaces the count at once. The third is a background load, which changes only the value used at the next reload. The control word is read back so that the neighbouring prescaler and interrupt-mask logic can use its fields. The count and the reload value are also read back. The channel can run on the full count width or on only the low half. In the narrow setting the upper half of the count is left untouched.

Top module: `dct_timer`

## Requirements
- R1: After reset, `ctrl_o` is 0x20, `reload_o` is 0, `count_o` is 0xFFFFFFFF and `zero_evt` is low.
- R2: A control write stores the 8-bit word, which appears on `ctrl_o` the next cycle. The field layout is: bit 7 enable, bit 6 periodic (1) or wrap (0), bit 5 interrupt enable, bits 3:2 prescale select, bit 1 wide (1 = 32-bit, 0 = 16-bit), bit 0 one-shot. Bit 4 always reads 0.
- R3: On a cycle with `tick` high, enable set and the channel not halted, the active part of the count drops by one.
- R4: In wrap mode, a tick that finds the active count at zero pulses `zero_evt` on the next cycle. The active part of the count then becomes all-ones, whatever the reload value.
- R5: In periodic mode, a tick that finds the active count at zero pulses `zero_evt`. The active part of the count is then reloaded from `reload_o`.
- R6: In one-shot mode, a tick that finds zero pulses `zero_evt` once. The count then stays at zero with no further events until a direct load. The periodic bit has no effect in this mode.
- R7: In 16-bit mode, only bits 15:0 decrement, wrap and reload, and zero is detected on those bits alone. Bits 31:16 keep their value.
- R8: A direct load shows its value on `count_o` and `reload_o` the next cycle. This happens without a tick and whether or not the channel is enabled. The direct load takes priority over a tick in the same cycle.
- R9: A background load changes `reload_o` only. The count goes on unchanged, and the new value is taken at the next zero.
- R10: If a background load and a direct load both occur with no tick between them, in either order or in the same cycle, the count takes the direct value and `reload_o` keeps the background value.
- R11: A load value of 0 produces `zero_evt` on the first tick after the load.
- R12: With enable clear, the count holds its value. Setting enable again resumes from that value.
- R13: `zero_evt` is high only in the cycle after a tick seen while enable was set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Qualified count pulse from the prescaler |
| ctrl_we | input | 1 | Control word write strobe |
| ctrl_wdata | input | 8 | Control word |
| ld_we | input | 1 | Direct load strobe |
| ld_data | input | 32 | Direct load value |
| bg_we | input | 1 | Background load strobe |
| bg_data | input | 32 | Background load value |
| count_o | output | 32 | Current count |
| reload_o | output | 32 | Reload value read back |
| ctrl_o | output | 8 | Control word read back |
| zero_evt | output | 1 | One-cycle zero-reached event |

## Verification
The hardest case to reach is a background load and a direct load that both fall within one gap between ticks. The outcome depends on whether the background write came first, came last or came in the same cycle. The stimulus keeps `tick` low and issues each ordering in turn, and in one case presents both strobes in a single cycle. It then checks `count_o` and `reload_o` directly. Finally it counts down to zero to show which value the periodic reload takes. The one-shot halt is reached by running extra ticks after the event and confirming that no second event appears and the count stays at zero.

// File: rtl/dct_pkg.sv
// Package: shared types and helpers for the down-counter timer channel.
// Assumes an 8-bit control word whose field positions are fixed below.
package dct_pkg;

    localparam int CTRL_W = 8;

    // Control field bit positions
    localparam int B_EN     = 7;
    localparam int B_PER    = 6;
    localparam int B_IRQ    = 5;
    localparam int B_PRE_HI = 3;
    localparam int B_PRE_LO = 2;
    localparam int B_WIDE   = 1;
    localparam int B_ONE    = 0;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 8'h20;
    localparam logic [CTRL_W-1:0] CTRL_MASK  = 8'hEF;

    typedef enum logic [1:0] {
        MODE_WRAP     = 2'd0,
        MODE_PERIODIC = 2'd1,
        MODE_ONESHOT  = 2'd2
    } run_mode_e;

    typedef struct packed {
        logic      enable;
        logic      wide;
        run_mode_e mode;
    } chan_cfg_t;

    // Decode the control word into the fields the counter needs
    function automatic chan_cfg_t decode_ctrl(input logic [CTRL_W-1:0] c);
        chan_cfg_t r;
        r.enable = c[B_EN];
        r.wide   = c[B_WIDE];
        if (c[B_ONE])
            r.mode = MODE_ONESHOT;
        else if (c[B_PER])
            r.mode = MODE_PERIODIC;
        else
            r.mode = MODE_WRAP;
        return r;
    endfunction

endpackage

// File: rtl/dct_ctrl_reg.sv
// Control register: stores the control word and decodes it.
// Assumes the write strobe is already decoded by the bus block.
module dct_ctrl_reg
    import dct_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [CTRL_W-1:0] wdata,
    output logic [CTRL_W-1:0] ctrl_q,
    output chan_cfg_t         cfg
);

    // Hold the control word, masking off unused bits
    always_ff @(posedge clk) begin
        if (!rst_n)
            ctrl_q <= CTRL_RESET;
        else if (we)
            ctrl_q <= wdata & CTRL_MASK;
    end

    // Present decoded mode and width
    always_comb begin
        cfg = decode_ctrl(ctrl_q);
    end

endmodule

// File: rtl/dct_reload.sv
// Reload register: holds the value used at periodic reloads.
// A background write wins over any direct write made before the next tick.
module dct_reload #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             ld_we,
    input  logic [CNT_W-1:0] ld_data,
    input  logic             bg_we,
    input  logic [CNT_W-1:0] bg_data,
    output logic [CNT_W-1:0] reload_q
);

    logic bg_seen_q;

    // Remember a background write until the next tick
    always_ff @(posedge clk) begin
        if (!rst_n)
            bg_seen_q <= 1'b0;
        else if (bg_we)
            bg_seen_q <= 1'b1;
        else if (tick)
            bg_seen_q <= 1'b0;
    end

    // Update the reload value, background write first
    always_ff @(posedge clk) begin
        if (!rst_n)
            reload_q <= '0;
        else if (bg_we)
            reload_q <= bg_data;
        else if (ld_we && !bg_seen_q)
            reload_q <= ld_data;
    end

endmodule

// File: rtl/dct_core.sv
// Count datapath: decrement, zero detect, wrap/reload/halt, event pulse.
// Assumes tick is a single-cycle qualified pulse; narrow mode uses the low
// NARROW_W bits and leaves the upper bits alone.
module dct_core
    import dct_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  chan_cfg_t        cfg,
    input  logic             ld_we,
    input  logic [CNT_W-1:0] ld_data,
    input  logic [CNT_W-1:0] reload,
    output logic [CNT_W-1:0] count_q,
    output logic             evt_q
);

    localparam int UPPER_W = CNT_W - NARROW_W;

    logic             halt_q;
    logic [CNT_W-1:0] count_d;
    logic             halt_d;
    logic             evt_d;
    logic             at_zero;
    logic             step;
    logic [CNT_W-1:0] dec_val;
    logic [CNT_W-1:0] wrap_val;
    logic [CNT_W-1:0] rld_val;

    // Build width-dependent next values
    generate
        if (UPPER_W > 0) begin : g_split
            always_comb begin
                at_zero  = cfg.wide ? (count_q == '0)
                                    : (count_q[NARROW_W-1:0] == '0);
                dec_val  = cfg.wide ? count_q - 1'b1
                                    : {count_q[CNT_W-1:NARROW_W],
                                       count_q[NARROW_W-1:0] - 1'b1};
                wrap_val = cfg.wide ? '1
                                    : {count_q[CNT_W-1:NARROW_W], {NARROW_W{1'b1}}};
                rld_val  = cfg.wide ? reload
                                    : {count_q[CNT_W-1:NARROW_W],
                                       reload[NARROW_W-1:0]};
            end
        end else begin : g_flat
            always_comb begin
                at_zero  = (count_q == '0);
                dec_val  = count_q - 1'b1;
                wrap_val = '1;
                rld_val  = reload;
            end
        end
    endgenerate

    // Choose next count, halt and event
    always_comb begin
        step    = tick && cfg.enable && !halt_q;
        count_d = count_q;
        halt_d  = halt_q;
        evt_d   = 1'b0;
        if (ld_we) begin
            count_d = ld_data;
            halt_d  = 1'b0;
        end else if (step) begin
            if (at_zero) begin
                evt_d = 1'b1;
                unique case (cfg.mode)
                    MODE_ONESHOT:  halt_d  = 1'b1;
                    MODE_PERIODIC: count_d = rld_val;
                    default:       count_d = wrap_val;
                endcase
            end else begin
                count_d = dec_val;
            end
        end
    end

    // Register count, halt flag and event
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '1;
            halt_q  <= 1'b0;
            evt_q   <= 1'b0;
        end else begin
            count_q <= count_d;
            halt_q  <= halt_d;
            evt_q   <= evt_d;
        end
    end

endmodule

// File: rtl/dct_timer.sv
// Top of one down-counter timer channel: control register, reload register
// and count datapath. Assumes one clock, synchronous active-low reset and
// strobes decoded by a neighbouring bus block.
module dct_timer
    import dct_pkg::*;
#(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              ctrl_we,
    input  logic [CTRL_W-1:0] ctrl_wdata,
    input  logic              ld_we,
    input  logic [CNT_W-1:0]  ld_data,
    input  logic              bg_we,
    input  logic [CNT_W-1:0]  bg_data,
    output logic [CNT_W-1:0]  count_o,
    output logic [CNT_W-1:0]  reload_o,
    output logic [CTRL_W-1:0] ctrl_o,
    output logic              zero_evt
);

    chan_cfg_t cfg;

    dct_ctrl_reg u_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (ctrl_we),
        .wdata  (ctrl_wdata),
        .ctrl_q (ctrl_o),
        .cfg    (cfg)
    );

    dct_reload #(.CNT_W(CNT_W)) u_reload (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .ld_we    (ld_we),
        .ld_data  (ld_data),
        .bg_we    (bg_we),
        .bg_data  (bg_data),
        .reload_q (reload_o)
    );

    dct_core #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_core (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .cfg     (cfg),
        .ld_we   (ld_we),
        .ld_data (ld_data),
        .reload  (reload_o),
        .count_q (count_o),
        .evt_q   (zero_evt)
    );

endmodule

// File: rtl/dct_timer_chk.sv
// Checker for the timer channel, bound to the top module.
module dct_timer_chk #(
    parameter int CNT_W    = 32,
    parameter int NARROW_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             tick,
    input logic             ld_we,
    input logic [CNT_W-1:0] ld_data,
    input logic             bg_we,
    input logic [CNT_W-1:0] count_o,
    input logic [CNT_W-1:0] reload_o,
    input logic [7:0]       ctrl_o,
    input logic             zero_evt
);

    // R13
    evt_after_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        zero_evt |-> ($past(tick) && $past(ctrl_o[7])));

    // R12
    frozen_when_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[7] && !ld_we) |=> $stable(count_o));

    // R8
    load_visible_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ld_we |=> (count_o == $past(ld_data)));

    // R4
    wide_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (zero_evt && $past(ctrl_o[1]) && !$past(ctrl_o[6]) && !$past(ctrl_o[0]))
        |-> (count_o == {CNT_W{1'b1}}));

    // R7
    upper_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl_o[1] && !ld_we) |=> (count_o[CNT_W-1:NARROW_W] == $past(count_o[CNT_W-1:NARROW_W])));

    // R9
    reload_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ld_we && !bg_we) |=> $stable(reload_o));

endmodule

bind dct_timer dct_timer_chk #(.CNT_W(CNT_W), .NARROW_W(NARROW_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .tick     (tick),
    .ld_we    (ld_we),
    .ld_data  (ld_data),
    .bg_we    (bg_we),
    .count_o  (count_o),
    .reload_o (reload_o),
    .ctrl_o   (ctrl_o),
    .zero_evt (zero_evt)
);

// File: tb/dct_timer_tb.sv
module dct_timer_tb;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC = 12;

    // {ctrl[8], load[32], ticks[8], exp_count[32], exp_events[8]}
    localparam logic [87:0] VEC [NVEC] = '{
        {8'h82, 32'h0000_0005, 8'd3, 32'h0000_0002, 8'd0},   // R3
        {8'h82, 32'h0000_0002, 8'd3, 32'hFFFF_FFFF, 8'd1},   // R4
        {8'h82, 32'h0000_0002, 8'd5, 32'hFFFF_FFFD, 8'd1},   // R4
        {8'hC2, 32'h0000_0003, 8'd9, 32'h0000_0002, 8'd2},   // R5
        {8'h83, 32'h0000_0002, 8'd6, 32'h0000_0000, 8'd1},   // R6
        {8'hC3, 32'h0000_0002, 8'd6, 32'h0000_0000, 8'd1},   // R6
        {8'h80, 32'h0001_0002, 8'd3, 32'h0001_FFFF, 8'd1},   // R7
        {8'hC0, 32'hABCD_0001, 8'd3, 32'hABCD_0000, 8'd1},   // R7
        {8'hC2, 32'h0000_0000, 8'd3, 32'h0000_0000, 8'd3},   // R11
        {8'h02, 32'h0000_0007, 8'd4, 32'h0000_0007, 8'd0},   // R12
        {8'h81, 32'h5555_0001, 8'd4, 32'h5555_0000, 8'd1},   // R6
        {8'h80, 32'h0000_0000, 8'd1, 32'h0000_FFFF, 8'd1}    // R11
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [7:0]  ctrl_wdata = '0;
    logic        ld_we = 1'b0;
    logic [31:0] ld_data = '0;
    logic        bg_we = 1'b0;
    logic [31:0] bg_data = '0;
    logic [31:0] count_o;
    logic [31:0] reload_o;
    logic [7:0]  ctrl_o;
    logic        zero_evt;

    int checks = 0;
    int errors = 0;
    int evts;

    always #(CLK_PERIOD/2) clk = ~clk;

    dct_timer u_dut (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (tick),
        .ctrl_we    (ctrl_we),
        .ctrl_wdata (ctrl_wdata),
        .ld_we      (ld_we),
        .ld_data    (ld_data),
        .bg_we      (bg_we),
        .bg_data    (bg_data),
        .count_o    (count_o),
        .reload_o   (reload_o),
        .ctrl_o     (ctrl_o),
        .zero_evt   (zero_evt)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr_ctrl(input logic [7:0] v);
        ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk);
        ctrl_we = 1'b0;
    endtask

    task automatic wr_ld(input logic [31:0] v);
        ld_we = 1'b1; ld_data = v;
        @(negedge clk);
        ld_we = 1'b0;
    endtask

    task automatic wr_bg(input logic [31:0] v);
        bg_we = 1'b1; bg_data = v;
        @(negedge clk);
        bg_we = 1'b0;
    endtask

    // Apply n ticks back to back, counting events seen
    task automatic run_ticks(input int n);
        evts = 0;
        for (int i = 0; i < n; i++) begin
            tick = 1'b1;
            @(negedge clk);
            if (zero_evt) evts++;
        end
        tick = 1'b0;
        @(negedge clk);
        if (zero_evt) evts++;
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 20000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        check("R1 ctrl", {24'h0, ctrl_o}, 32'h20);
        check("R1 reload", reload_o, 32'h0);
        check("R1 count", count_o, 32'hFFFF_FFFF);
        check("R1 evt", {31'h0, zero_evt}, 32'h0);
        rst_n = 1'b1;
        @(negedge clk);

        // R13: ticks while disabled raise no event
        run_ticks(3);
        check("R13 no evt when disabled", evts, 0);

        // Vector table: R3 R4 R5 R6 R7 R11 R12
        for (int v = 0; v < NVEC; v++) begin
            wr_ctrl(VEC[v][87:80]);
            wr_ld(VEC[v][79:48]);
            check("R8 load visible", count_o, VEC[v][79:48]);
            check("R8 reload follows", reload_o, VEC[v][79:48]);
            run_ticks(int'(VEC[v][47:40]));
            check($sformatf("R3-vec%0d count", v), count_o, VEC[v][39:8]);
            check($sformatf("R13-vec%0d events", v), evts, int'(VEC[v][7:0]));
        end

        // R2 control word with bit 4 masked
        wr_ctrl(8'hFF);
        check("R2 ctrl readback", {24'h0, ctrl_o}, 32'hEF);

        // R9 background load
        wr_ctrl(8'hC2);
        wr_ld(32'd4);
        wr_bg(32'd9);
        check("R9 count untouched", count_o, 32'd4);
        check("R9 reload updated", reload_o, 32'd9);
        run_ticks(5);
        check("R9 reload at zero", count_o, 32'd9);
        check("R9 one event", evts, 1);

        // R10 background then direct
        wr_bg(32'd20);
        wr_ld(32'd6);
        check("R10 count direct", count_o, 32'd6);
        check("R10 reload keeps bg", reload_o, 32'd20);
        run_ticks(7);
        check("R10 reload used", count_o, 32'd20);

        // R10 same-cycle write
        ld_we = 1'b1; ld_data = 32'd3; bg_we = 1'b1; bg_data = 32'd11;
        @(negedge clk);
        ld_we = 1'b0; bg_we = 1'b0;
        check("R10 same-cycle count", count_o, 32'd3);
        check("R10 same-cycle reload", reload_o, 32'd11);

        // R8 load wins over tick in same cycle
        tick = 1'b1; ld_we = 1'b1; ld_data = 32'd50;
        @(negedge clk);
        tick = 1'b0; ld_we = 1'b0;
        check("R8 load over tick", count_o, 32'd50);

        // R12 freeze and resume
        wr_ctrl(8'h82);
        wr_ld(32'd10);
        run_ticks(3);
        check("R12 before freeze", count_o, 32'd7);
        wr_ctrl(8'h02);
        run_ticks(3);
        check("R12 frozen", count_o, 32'd7);
        wr_ctrl(8'h82);
        run_ticks(2);
        check("R12 resumed", count_o, 32'd5);

        // R6 restart after halt by direct load
        wr_ctrl(8'h83);
        wr_ld(32'd1);
        run_ticks(5);
        check("R6 halted", count_o, 32'd0);
        check("R6 single event", evts, 1);
        wr_ld(32'd1);
        run_ticks(2);
        check("R6 restart event", evts, 1);

        finish_run();
    end

endmodule